// File: doc/BRIEF.md
# Commit-Stage Checker Exception Arbiter

This block sits at the commit point of an in-order result checker that re-verifies instructions coming out of a speculative core. Instructions arrive one at a time, oldest first. Each one carries four error flags raised by the checking pipelines: forward-progress timeout, bad register operand, bad memory operand and bad computed result. Each also carries the corrected values those pipelines produced, its own PC and the address of the next instruction. If no flag is raised, the instruction retires in the same cycle.

If any flag is raised, the arbiter takes exactly one exception. It picks the highest-priority flag and latches the matching corrected value. It then runs a fixed recovery sequence. First it patches the value into the instruction. Next it asks the checker pipes to restart at the instruction's own PC, so the same instruction is checked again, and holds that request until the pipes acknowledge it. Finally it flushes the core with a restart at the next PC.

While recovery is running, nothing retires and no new instruction is accepted. An instruction can therefore loop through several single-fault recoveries before it finally retires clean.

Top module: `ckx_commit_arb`

## Requirements
- R1: After reset, `in_ready` is 1 and `retire_en`, `patch_valid`, `chk_restart` and `core_flush` are all 0.
- R2: When `in_ready` and `in_valid` are 1 and all of `err_flags` are 0, `retire_en` is 1 in that same cycle and no recovery follows.
- R3: Flag bit positions are: bit 0 timeout, bit 1 register operand, bit 2 memory operand, bit 3 computed result. Bit 0 has the highest priority and bit 3 the lowest. When an instruction is accepted with any flag set, the cycle after acceptance shows `patch_valid` = 1 for exactly one cycle, with `patch_sel` equal to the index of the lowest set bit.
- R4: `patch_val` carries zero for code 0, `reg_fix_val` for code 1, `mem_fix_val` for code 2 and `res_fix_val` for code 3. All of these are taken as they stood in the acceptance cycle.
- R5: The cycle after the patch, `chk_restart` is 1 with `chk_restart_pc` equal to the accepted `inst_pc`. Both hold until the cycle in which `chk_restart_ack` is 1.
- R6: The cycle after the acknowledge, `core_flush` is 1 for exactly one cycle, with `core_restart_pc` equal to the accepted `inst_npc`.
- R7: From the patch cycle through the flush cycle, `in_ready` and `retire_en` are 0. Any activity on the instruction inputs in that window has no effect on the outputs or on the latched values.
- R8: `retire_en` is never 1 in a cycle in which any flag of the presented instruction is set.
- R9: `in_ready` returns to 1 in the cycle right after the flush, so a re-check of the same instruction can be accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented at commit |
| in_ready | output | 1 | Arbiter can accept an instruction |
| err_flags | input | 4 | Error flags, bit 0 has the highest priority |
| reg_fix_val | input | DW | Register operand read from architected state |
| mem_fix_val | input | DW | Memory operand read from architected state |
| res_fix_val | input | DW | Result recomputed by the checker |
| inst_pc | input | AW | PC of the presented instruction |
| inst_npc | input | AW | Next-instruction PC |
| retire_en | output | 1 | Commit the presented instruction |
| patch_valid | output | 1 | Correction strobe |
| patch_sel | output | 2 | Correction source code |
| patch_val | output | DW | Corrected value |
| chk_restart | output | 1 | Restart request to checker pipes |
| chk_restart_pc | output | AW | Checker restart PC |
| chk_restart_ack | input | 1 | Checker pipes accept the restart |
| core_flush | output | 1 | Flush the core |
| core_restart_pc | output | AW | Core restart PC |

## Verification
A wrong priority encoding or a wrong mux selection shows up one cycle after acceptance, as a bad `patch_sel` or `patch_val`. A sequencer stuck in a wrong state shows up in two ways: the restart request may not be held across a late acknowledge, or the flush may land on the wrong cycle or carry the wrong PC. A broken busy gate shows up as `retire_en` or `in_ready` rising inside the recovery window.

The sweep covers all sixteen flag combinations, each with four acknowledge delays. During every recovery it pushes decoy instructions into the inputs, so a latch that is not held still shows up at the restart and flush PCs.

// File: rtl/ckx_arb_pkg.sv
package ckx_arb_pkg;
  localparam int unsigned NUM_EXC = 4;
  localparam int unsigned CODE_W  = $clog2(NUM_EXC);

  typedef enum logic [CODE_W-1:0] {
    FIX_WDOG = 2'd0,
    FIX_REG  = 2'd1,
    FIX_MEM  = 2'd2,
    FIX_RES  = 2'd3
  } fix_src_e;

  typedef enum logic [1:0] {
    RS_IDLE    = 2'd0,
    RS_PATCH   = 2'd1,
    RS_RESTART = 2'd2,
    RS_FLUSH   = 2'd3
  } rec_state_e;
endpackage

// File: rtl/ckx_prio_enc.sv
module ckx_prio_enc
  import ckx_arb_pkg::*;
#(
  parameter int unsigned NF = NUM_EXC,
  localparam int unsigned CW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF-1:0] flags,
  output logic          any,
  output logic [CW-1:0] code
);
  logic [NF-1:0] grant;

  assign grant[0] = flags[0];
  for (genvar g = 1; g < NF; g++) begin : g_grant
    assign grant[g] = flags[g] & ~(|flags[g-1:0]);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NF; i++) begin
      if (grant[i]) code = CW'(i);
    end
  end

  assign any = |flags;
endmodule

// File: rtl/ckx_fix_mux.sv
module ckx_fix_mux
  import ckx_arb_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fix_src_e        sel,
  input  logic [DW-1:0]   reg_val,
  input  logic [DW-1:0]   mem_val,
  input  logic [DW-1:0]   res_val,
  output logic [DW-1:0]   out_val
);
  always_comb begin
    unique case (sel)
      FIX_WDOG: out_val = '0;
      FIX_REG:  out_val = reg_val;
      FIX_MEM:  out_val = mem_val;
      FIX_RES:  out_val = res_val;
      default:  out_val = '0;
    endcase
  end
endmodule

// File: rtl/ckx_rec_fsm.sv
module ckx_rec_fsm
  import ckx_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic idle,
  output logic in_patch,
  output logic in_restart,
  output logic in_flush
);
  rec_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RS_IDLE:    if (start) st_d = RS_PATCH;
      RS_PATCH:   st_d = RS_RESTART;
      RS_RESTART: if (ack) st_d = RS_FLUSH;
      RS_FLUSH:   st_d = RS_IDLE;
      default:    st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  assign idle       = (st_q == RS_IDLE);
  assign in_patch   = (st_q == RS_PATCH);
  assign in_restart = (st_q == RS_RESTART);
  assign in_flush   = (st_q == RS_FLUSH);
endmodule

// File: rtl/ckx_commit_arb.sv
module ckx_commit_arb
  import ckx_arb_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NUM_EXC-1:0] err_flags,
  input  logic [DW-1:0]     reg_fix_val,
  input  logic [DW-1:0]     mem_fix_val,
  input  logic [DW-1:0]     res_fix_val,
  input  logic [AW-1:0]     inst_pc,
  input  logic [AW-1:0]     inst_npc,
  output logic              retire_en,
  output logic              patch_valid,
  output logic [CODE_W-1:0] patch_sel,
  output logic [DW-1:0]     patch_val,
  output logic              chk_restart,
  output logic [AW-1:0]     chk_restart_pc,
  input  logic              chk_restart_ack,
  output logic              core_flush,
  output logic [AW-1:0]     core_restart_pc
);
  logic              any_err;
  logic [CODE_W-1:0] win_code;
  logic [DW-1:0]     fix_val;
  logic              idle, in_patch, in_restart, in_flush;
  logic              take_exc;

  logic [CODE_W-1:0] sel_q;
  logic [DW-1:0]     val_q;
  logic [AW-1:0]     pc_q, npc_q;

  ckx_prio_enc #(.NF(NUM_EXC)) u_prio (
    .flags (err_flags),
    .any   (any_err),
    .code  (win_code)
  );

  ckx_fix_mux #(.DW(DW)) u_mux (
    .sel     (fix_src_e'(win_code)),
    .reg_val (reg_fix_val),
    .mem_val (mem_fix_val),
    .res_val (res_fix_val),
    .out_val (fix_val)
  );

  assign take_exc = idle && in_valid && any_err;

  ckx_rec_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take_exc),
    .ack        (chk_restart_ack),
    .idle       (idle),
    .in_patch   (in_patch),
    .in_restart (in_restart),
    .in_flush   (in_flush)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      val_q <= '0;
      pc_q  <= '0;
      npc_q <= '0;
    end else if (take_exc) begin
      sel_q <= win_code;
      val_q <= fix_val;
      pc_q  <= inst_pc;
      npc_q <= inst_npc;
    end
  end

  assign in_ready        = idle;
  assign retire_en       = idle && in_valid && !any_err;
  assign patch_valid     = in_patch;
  assign patch_sel       = sel_q;
  assign patch_val       = val_q;
  assign chk_restart     = in_restart;
  assign chk_restart_pc  = pc_q;
  assign core_flush      = in_flush;
  assign core_restart_pc = npc_q;
endmodule

module ckx_commit_arb_chk
  import ckx_arb_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [NUM_EXC-1:0] err_flags,
  input logic              retire_en,
  input logic              patch_valid,
  input logic [CODE_W-1:0] patch_sel,
  input logic              chk_restart,
  input logic [AW-1:0]     chk_restart_pc,
  input logic              chk_restart_ack,
  input logic              core_flush
);
  p_clean_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retire_en |-> (err_flags == '0) && in_ready);
  p_busy_no_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !retire_en);
  p_patch_then_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    patch_valid |=> !patch_valid && chk_restart);
  p_restart_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_restart && !chk_restart_ack |=> chk_restart && $stable(chk_restart_pc));
  p_flush_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_restart && chk_restart_ack |=> core_flush);
  p_ready_after_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_flush |=> in_ready && !core_flush);
  p_top_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && err_flags[0] |=> patch_valid && patch_sel == 2'd0);
  p_reg_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && err_flags[1:0] == 2'b10 |=> patch_valid && patch_sel == 2'd1);
  p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retire_en, patch_valid, chk_restart, core_flush}));
endmodule

bind ckx_commit_arb ckx_commit_arb_chk #(.AW(AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .err_flags       (err_flags),
  .retire_en       (retire_en),
  .patch_valid     (patch_valid),
  .patch_sel       (patch_sel),
  .chk_restart     (chk_restart),
  .chk_restart_pc  (chk_restart_pc),
  .chk_restart_ack (chk_restart_ack),
  .core_flush      (core_flush)
);

// File: tb/ckx_commit_arb_tb.sv
module ckx_commit_arb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  err_flags = '0;
  logic [31:0] reg_fix_val = '0, mem_fix_val = '0, res_fix_val = '0;
  logic [31:0] inst_pc = '0, inst_npc = '0;
  logic        retire_en, patch_valid, chk_restart, core_flush;
  logic [1:0]  patch_sel;
  logic [31:0] patch_val, chk_restart_pc, core_restart_pc;
  logic        chk_restart_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ckx_commit_arb u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .err_flags(err_flags), .reg_fix_val(reg_fix_val), .mem_fix_val(mem_fix_val),
    .res_fix_val(res_fix_val), .inst_pc(inst_pc), .inst_npc(inst_npc),
    .retire_en(retire_en), .patch_valid(patch_valid), .patch_sel(patch_sel),
    .patch_val(patch_val), .chk_restart(chk_restart), .chk_restart_pc(chk_restart_pc),
    .chk_restart_ack(chk_restart_ack), .core_flush(core_flush),
    .core_restart_pc(core_restart_pc)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic decoy();
    in_valid    = 1'b1;
    err_flags   = 4'h0;
    reg_fix_val = 32'hDEAD_0001;
    mem_fix_val = 32'hDEAD_0002;
    res_fix_val = 32'hDEAD_0003;
    inst_pc     = 32'hFFFF_0000;
    inst_npc    = 32'hFFFF_0004;
  endtask

  task automatic run_one(input int f, input int d);
    int          code;
    logic [31:0] rv, mv, sv, pc, npc, ev;
    rv  = 32'hA000_0000 | (f << 4) | d;
    mv  = 32'hB000_0000 | (f << 4) | d;
    sv  = 32'hC000_0000 | (f << 4) | d;
    pc  = 32'h0000_1000 + 32'((f * 4 + d) * 8);
    npc = pc + 32'd4;
    code = 0;
    for (int b = 3; b >= 0; b--) if (f[b]) code = b;
    case (code)
      0: ev = 32'h0;
      1: ev = rv;
      2: ev = mv;
      default: ev = sv;
    endcase

    @(negedge clk);
    in_valid = 1'b1; err_flags = 4'(f);
    reg_fix_val = rv; mem_fix_val = mv; res_fix_val = sv;
    inst_pc = pc; inst_npc = npc;
    #1;
    check({31'b0, in_ready}, 32'd1, "R9 ready before accept");
    check({31'b0, retire_en}, (f == 0) ? 32'd1 : 32'd0, (f == 0) ? "R2 clean retire" : "R8 no retire with flag");
    @(negedge clk);
    if (f == 0) begin
      in_valid = 1'b0;
      #1;
      check({31'b0, patch_valid}, 32'd0, "R2 no recovery after clean");
      check({31'b0, in_ready}, 32'd1, "R2 ready after clean");
      return;
    end
    decoy();
    #1;
    check({31'b0, patch_valid}, 32'd1, "R3 patch strobe");
    check({30'b0, patch_sel}, 32'(code), "R3 priority code");
    check(patch_val, ev, "R4 patch value");
    check({31'b0, in_ready}, 32'd0, "R7 busy in patch");
    check({31'b0, retire_en}, 32'd0, "R7 no retire in patch");
    @(negedge clk);
    for (int k = 0; k <= d; k++) begin
      #1;
      check({31'b0, chk_restart}, 32'd1, "R5 restart held");
      check(chk_restart_pc, pc, "R5 restart pc");
      check({31'b0, patch_valid | core_flush | retire_en}, 32'd0, "R7 quiet in restart");
      if (k == d) chk_restart_ack = 1'b1;
      @(negedge clk);
    end
    chk_restart_ack = 1'b0;
    #1;
    check({31'b0, core_flush}, 32'd1, "R6 flush");
    check(core_restart_pc, npc, "R6 flush pc");
    check({31'b0, chk_restart | in_ready | retire_en}, 32'd0, "R7 quiet in flush");
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    check({31'b0, in_ready}, 32'd1, "R9 ready after flush");
    check({31'b0, core_flush}, 32'd0, "R6 flush single cycle");
  endtask

  initial begin
    #3;
    check({31'b0, in_ready}, 32'd1, "R1 reset ready");
    check({28'b0, retire_en, patch_valid, chk_restart, core_flush}, 32'd0, "R1 reset strobes");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 16; f++)
      for (int d = 0; d < 4; d++)
        run_one(f, d);
    // re-check loop: same instruction fixed one fault at a time (R9)
    run_one(15, 0); run_one(14, 1); run_one(12, 0); run_one(8, 2); run_one(0, 0);
    done = 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1;
    end
  end

  initial begin
    wait (done);
    #10;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule